// File: doc/BRIEF.md
# Per-Channel Latched Fault Event Register

This block keeps a sticky record of fault events for a power switch controller with several channels. Each channel reports two kinds of one-cycle fault pulse. The first is a current-limit timeout: the channel held its output at the current limit, or at the folded-back limit, for longer than the allowed time. The second is a start fault: a start-up timeout, or a detection or classification error while the channel was turning on. Each pulse sets a bit, and the bit stays set until something clears it.

A register-read port reads the bits through a one-cycle strobe and a command code. One code returns the bits and leaves them unchanged. A second code returns the same bits and clears the register in the same edge. When a channel is switched off, that channel's bits are cleared. In automatic mode, start faults caused by invalid discovery are discarded.

An interrupt request follows the masked register contents combinationally. For every start fault that is latched, the block also decides where the fault goes. If the channel's power-enable-change flag is set, the fault is flagged as inrush. Otherwise its cause code is written out to a separate power-on fault cause store. The read port has no back-pressure: a strobe is accepted in every cycle, and the response is a one-cycle pulse that the consumer must take when it appears.

Top module: `fault_event_latch`

## Requirements
- R1: While reset is asserted, and after it is released, every register bit is 0, `irq` is low, and `rd_valid`, `inrush_evt` and `pof_wr` are all low.
- R2: A pulse on `ilim_evt[i]` sets register bit NCH+i. With the default NCH=4, channels 1 to 4 map to bits 4 to 7. The bit stays set until a clearing read or a channel-off clears it.
- R3: A pulse on `start_evt[i]` that is not suppressed sets register bit i (bits 0 to 3 for channels 1 to 4). The bit is sticky.
- R4: Start cause codes are 2 bits wide: 0 = start-up timeout, 1 = detection invalid, 2 = classification invalid, 3 = other. When `auto_mode[i]` is 1 and the cause is 1 or 2, the start pulse is dropped. It sets no bit and produces no `pof_wr` or `inrush_evt` pulse. In automatic mode, cause 0 is still latched.
- R5: A strobe with command 8'h08 returns the register value from before the edge and leaves the register unchanged.
- R6: A strobe with command 8'h09 returns the register value from before the edge and clears every bit. A fault event in the same cycle still sets its bit after the clear.
- R7: A strobe with any other command returns 0 and has no effect on the register.
- R8: A pulse on `chan_off[i]` clears bits i and NCH+i. A fault event for the same channel in the same cycle is discarded.
- R9: `irq` equals the OR of (register AND `irq_mask`) and follows changes of the mask without a clock edge.
- R10: A start fault that is latched while `pec_flag[i]` is 1 pulses `inrush_evt[i]` one cycle later. Otherwise it pulses `pof_wr[i]`, and `pof_code[2i+1:2i]` then carries its cause. The two are never high together for the same channel.
- R11: `rd_valid` is high for exactly the one cycle after each strobe, with `rd_data` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ilim_evt | input | NCH | Current-limit timeout pulse for each channel |
| start_evt | input | NCH | Start fault pulse for each channel |
| start_cause | input | 2*NCH | Cause code of the start fault, 2 bits per channel |
| auto_mode | input | NCH | Channel is in automatic mode |
| pec_flag | input | NCH | Power-enable-change flag for each channel |
| chan_off | input | NCH | Channel switch-off pulse |
| irq_mask | input | 2*NCH | Interrupt enable for each register bit |
| rd_strobe | input | 1 | One-cycle read request |
| rd_cmd | input | 8 | Command code of the read |
| rd_valid | output | 1 | Read response valid, one cycle |
| rd_data | output | 2*NCH | Read response data |
| irq | output | 1 | Level interrupt request |
| inrush_evt | output | NCH | Start fault classified as inrush (pulse) |
| pof_wr | output | NCH | Start fault cause recorded (pulse) |
| pof_code | output | 2*NCH | Last recorded cause code for each channel |

## Verification
Three kinds of update can land on the same clock edge as the clearing read: a new fault event, a channel switch-off, and an event paired with a switch-off on the same channel. The stimulus table puts a current-limit pulse in the same cycle as a command 8'h09 strobe. The response must show the value from before the clear, and a later plain read must show only the new bit. A switch-off is also paired with an event on the same channel, and that bit must stay clear. These outcomes are judged through later reads and through `irq` with the mask fully open.

// File: rtl/fault_evt_pkg.sv
`timescale 1ns/1ps
package fault_evt_pkg;
  localparam logic [7:0] CMD_PEEK     = 8'h08;
  localparam logic [7:0] CMD_PEEK_CLR = 8'h09;

  typedef enum logic [1:0] {
    CAUSE_START_TMO = 2'd0,
    CAUSE_DET_BAD   = 2'd1,
    CAUSE_CLS_BAD   = 2'd2,
    CAUSE_OTHER     = 2'd3
  } start_cause_e;

  function automatic logic is_discovery(input logic [1:0] code);
    return (code == CAUSE_DET_BAD) || (code == CAUSE_CLS_BAD);
  endfunction
endpackage

// File: rtl/fault_evt_qualify.sv
`timescale 1ns/1ps
module fault_evt_qualify
  import fault_evt_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0]   ilim_evt,
  input  logic [NCH-1:0]   start_evt,
  input  logic [2*NCH-1:0] start_cause,
  input  logic [NCH-1:0]   auto_mode,
  input  logic [NCH-1:0]   chan_off,
  output logic [NCH-1:0]   ilim_set,
  output logic [NCH-1:0]   start_set
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic drop_start;
    always_comb begin
      drop_start   = auto_mode[i] && is_discovery(start_cause[2*i +: 2]);
      start_set[i] = start_evt[i] && !drop_start && !chan_off[i];
      ilim_set[i]  = ilim_evt[i] && !chan_off[i];
    end
  end
endmodule

// File: rtl/fault_evt_store.sv
`timescale 1ns/1ps
module fault_evt_store #(
  parameter int NCH = 4,
  localparam int DW = 2*NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  set_vec,
  input  logic [NCH-1:0] chan_off,
  input  logic           clr_all,
  output logic [DW-1:0]  evt_q
);
  logic [DW-1:0] off_mask;
  logic [DW-1:0] evt_d;

  always_comb begin
    off_mask = {chan_off, chan_off};
    evt_d    = ((clr_all ? '0 : evt_q) | set_vec) & ~off_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end
endmodule

// File: rtl/fault_evt_classify.sv
`timescale 1ns/1ps
module fault_evt_classify #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   start_set,
  input  logic [NCH-1:0]   pec_flag,
  input  logic [2*NCH-1:0] start_cause,
  output logic [NCH-1:0]   inrush_evt,
  output logic [NCH-1:0]   pof_wr,
  output logic [2*NCH-1:0] pof_code
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inrush_evt[i]    <= 1'b0;
        pof_wr[i]        <= 1'b0;
        pof_code[2*i +: 2] <= 2'd0;
      end else begin
        inrush_evt[i] <= start_set[i] && pec_flag[i];
        pof_wr[i]     <= start_set[i] && !pec_flag[i];
        if (start_set[i] && !pec_flag[i])
          pof_code[2*i +: 2] <= start_cause[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/fault_evt_rdport.sv
`timescale 1ns/1ps
module fault_evt_rdport
  import fault_evt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_strobe,
  input  logic [7:0]    rd_cmd,
  input  logic [DW-1:0] evt_q,
  output logic          clr_all,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic hit;

  always_comb begin
    hit     = rd_strobe && ((rd_cmd == CMD_PEEK) || (rd_cmd == CMD_PEEK_CLR));
    clr_all = rd_strobe && (rd_cmd == CMD_PEEK_CLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_strobe;
      if (rd_strobe) rd_data <= hit ? evt_q : '0;
    end
  end
endmodule

// File: rtl/fault_event_latch.sv
`timescale 1ns/1ps
module fault_event_latch #(
  parameter int NCH = 4,
  localparam int DW = 2*NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ilim_evt,
  input  logic [NCH-1:0] start_evt,
  input  logic [DW-1:0]  start_cause,
  input  logic [NCH-1:0] auto_mode,
  input  logic [NCH-1:0] pec_flag,
  input  logic [NCH-1:0] chan_off,
  input  logic [DW-1:0]  irq_mask,
  input  logic           rd_strobe,
  input  logic [7:0]     rd_cmd,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic           irq,
  output logic [NCH-1:0] inrush_evt,
  output logic [NCH-1:0] pof_wr,
  output logic [DW-1:0]  pof_code
);
  logic [NCH-1:0] ilim_set;
  logic [NCH-1:0] start_set;
  logic           clr_all;
  logic [DW-1:0]  evt_q;

  fault_evt_qualify #(.NCH(NCH)) u_qual (
    .ilim_evt(ilim_evt), .start_evt(start_evt), .start_cause(start_cause),
    .auto_mode(auto_mode), .chan_off(chan_off),
    .ilim_set(ilim_set), .start_set(start_set)
  );

  fault_evt_store #(.NCH(NCH)) u_store (
    .clk(clk), .rst_n(rst_n), .set_vec({ilim_set, start_set}),
    .chan_off(chan_off), .clr_all(clr_all), .evt_q(evt_q)
  );

  fault_evt_classify #(.NCH(NCH)) u_cls (
    .clk(clk), .rst_n(rst_n), .start_set(start_set), .pec_flag(pec_flag),
    .start_cause(start_cause), .inrush_evt(inrush_evt), .pof_wr(pof_wr),
    .pof_code(pof_code)
  );

  fault_evt_rdport #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_cmd(rd_cmd),
    .evt_q(evt_q), .clr_all(clr_all), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign irq = |(evt_q & irq_mask);
endmodule

// File: rtl/fault_event_latch_chk.sv
`timescale 1ns/1ps
module fault_event_latch_chk
  import fault_evt_pkg::*;
#(
  parameter int NCH = 4,
  localparam int DW = 2*NCH
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ilim_evt,
  input logic [NCH-1:0] start_evt,
  input logic [NCH-1:0] chan_off,
  input logic           rd_strobe,
  input logic [7:0]     rd_cmd,
  input logic           rd_valid,
  input logic           irq,
  input logic [NCH-1:0] inrush_evt,
  input logic [NCH-1:0] pof_wr,
  input logic [DW-1:0]  evt_q
);
  // R2 / R3: bits never fall without a clearing read or a switch-off
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_strobe && rd_cmd == CMD_PEEK_CLR) && chan_off == '0)
      |=> ((~evt_q & $past(evt_q)) == '0));

  // R5: a plain read with no other activity leaves the register unchanged
  p_peek_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rd_cmd == CMD_PEEK && ilim_evt == '0 && start_evt == '0
     && chan_off == '0) |=> $stable(evt_q));

  // R6: a clearing read with no new event drops the interrupt
  p_clear_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rd_cmd == CMD_PEEK_CLR && ilim_evt == '0 && start_evt == '0)
      |=> !irq);

  // R8: a switched-off channel holds no bits afterwards
  p_off_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_off != '0) |=> ((evt_q & {$past(chan_off), $past(chan_off)}) == '0));

  // R10: inrush and cause record are exclusive per channel
  p_class_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inrush_evt & pof_wr) == '0);

  // R11: response follows each strobe by exactly one cycle
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> rd_valid);
  p_rsp_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> !rd_valid);
endmodule

bind fault_event_latch fault_event_latch_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ilim_evt(ilim_evt), .start_evt(start_evt),
  .chan_off(chan_off), .rd_strobe(rd_strobe), .rd_cmd(rd_cmd),
  .rd_valid(rd_valid), .irq(irq), .inrush_evt(inrush_evt), .pof_wr(pof_wr),
  .evt_q(evt_q)
);

// File: tb/test_fault_event_latch.sv
`timescale 1ns/1ps
module test_fault_event_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ilim_evt = '0, start_evt = '0, auto_mode = '0, pec_flag = '0, chan_off = '0;
  logic [7:0] start_cause = '0, irq_mask = 8'hFF, rd_cmd = '0;
  logic       rd_strobe = 1'b0;
  logic       rd_valid, irq;
  logic [7:0] rd_data, pof_code;
  logic [3:0] inrush_evt, pof_wr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fault_event_latch i_fault_event_latch (
    .clk(clk), .rst_n(rst_n), .ilim_evt(ilim_evt), .start_evt(start_evt),
    .start_cause(start_cause), .auto_mode(auto_mode), .pec_flag(pec_flag),
    .chan_off(chan_off), .irq_mask(irq_mask), .rd_strobe(rd_strobe),
    .rd_cmd(rd_cmd), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq),
    .inrush_evt(inrush_evt), .pof_wr(pof_wr), .pof_code(pof_code)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // {ilim, start, off, strobe, cmd, exp_data, exp_irq}
  localparam int NV = 13;
  localparam logic [29:0] VEC [NV] = '{
    {4'b0001, 4'b0000, 4'b0000, 1'b0, 8'h00, 8'h00, 1'b1}, // R2 set bit 4
    {4'b0000, 4'b0000, 4'b0000, 1'b1, 8'h08, 8'h10, 1'b1}, // R5 plain read
    {4'b0000, 4'b0100, 4'b0000, 1'b0, 8'h00, 8'h00, 1'b1}, // R3 set bit 2
    {4'b0000, 4'b0000, 4'b0000, 1'b1, 8'h08, 8'h14, 1'b1}, // R5
    {4'b1000, 4'b0000, 4'b0000, 1'b1, 8'h09, 8'h14, 1'b1}, // R6 clear + event
    {4'b0000, 4'b0000, 4'b0000, 1'b1, 8'h08, 8'h80, 1'b1}, // R6 event kept
    {4'b0000, 4'b0000, 4'b0000, 1'b1, 8'h0A, 8'h00, 1'b1}, // R7 other code
    {4'b0011, 4'b1111, 4'b0000, 1'b0, 8'h00, 8'h00, 1'b1}, // R2 R3 multi
    {4'b0000, 4'b0000, 4'b0001, 1'b0, 8'h00, 8'h00, 1'b1}, // R8 off ch1
    {4'b0010, 4'b0000, 4'b0010, 1'b0, 8'h00, 8'h00, 1'b1}, // R8 off wins
    {4'b0000, 4'b0000, 4'b0000, 1'b1, 8'h08, 8'h8C, 1'b1}, // R7 R8 result
    {4'b0000, 4'b0000, 4'b0000, 1'b1, 8'h09, 8'h8C, 1'b0}, // R6 clear all
    {4'b0000, 4'b0000, 4'b0000, 1'b1, 8'h08, 8'h00, 1'b0}  // R6 empty
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5 * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 irq", irq, 0); chk("R1 rd_valid", rd_valid, 0);
    chk("R1 pof_wr", pof_wr, 0); chk("R1 inrush", inrush_evt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after release", irq, 0);

    for (int v = 0; v < NV; v++) begin
      {ilim_evt, start_evt, chan_off, rd_strobe, rd_cmd} = VEC[v][29:9];
      @(negedge clk);
      chk("R11 rd_valid", rd_valid, VEC[v][17]);
      if (VEC[v][17]) chk("R5/R6/R7 rd_data", rd_data, VEC[v][8:1]);
      chk("R9 irq", irq, VEC[v][0]);
    end
    {ilim_evt, start_evt, chan_off, rd_strobe, rd_cmd} = '0;
    @(negedge clk);
    chk("R11 rd_valid drops", rd_valid, 0);

    // R4: automatic mode drops discovery-caused start fault
    auto_mode = 4'b0010; start_cause = 8'b0000_0100; start_evt = 4'b0010;
    @(negedge clk);
    chk("R4 suppressed irq", irq, 0); chk("R4 no pof_wr", pof_wr, 0);
    chk("R4 no inrush", inrush_evt, 0);
    start_cause = 8'b0000_1000; // cause 2 on ch2
    @(negedge clk);
    chk("R4 class-invalid suppressed", irq, 0);
    start_cause = '0;           // cause 0 still latched
    @(negedge clk);
    start_evt = '0;
    chk("R4 timeout latched irq", irq, 1);
    chk("R10 pof_wr ch2", pof_wr, 4'b0010);
    chk("R10 pof_code ch2", pof_code[3:2], 0);
    rd_strobe = 1; rd_cmd = 8'h09;
    @(negedge clk);
    rd_strobe = 0; auto_mode = '0;
    chk("R4 read shows bit 1", rd_data, 8'h02);
    chk("R10 pof_wr pulse ends", pof_wr, 0);

    // R10: inrush vs cause record
    pec_flag = 4'b0100; start_evt = 4'b0100;
    @(negedge clk);
    chk("R10 inrush ch3", inrush_evt, 4'b0100); chk("R10 no pof_wr", pof_wr, 0);
    pec_flag = '0; start_evt = 4'b0001; start_cause = 8'b0000_0010;
    @(negedge clk);
    start_evt = '0; start_cause = '0;
    chk("R10 pof_wr ch1", pof_wr, 4'b0001);
    chk("R10 pof_code ch1", pof_code[1:0], 2);
    chk("R10 inrush clear", inrush_evt, 0);

    // R9: mask changes act without a clock edge (register = 0x05)
    #1 irq_mask = 8'hF0;
    #1 chk("R9 masked", irq, 0);
    irq_mask = 8'h04;
    #1 chk("R9 unmasked", irq, 1);
    irq_mask = 8'hFF;

    // R6/R11 clearing read then idle
    @(negedge clk);
    rd_strobe = 1; rd_cmd = 8'h09;
    @(negedge clk);
    rd_strobe = 0;
    chk("R6 data", rd_data, 8'h05); chk("R11 valid", rd_valid, 1);
    chk("R6 irq low", irq, 0);
    @(negedge clk);
    chk("R11 valid one cycle", rd_valid, 0);

    // R1: reset mid-run clears state
    ilim_evt = 4'b1111;
    @(negedge clk);
    ilim_evt = '0;
    rst_n = 1'b0;
    #1 chk("R1 async reset irq", irq, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq stays low", irq, 0);

    finish_run();
  end
endmodule